// File: doc/BRIEF.md
# Serial Overhead Bit Insertion Controller

This block lives on the terminal-equipment side of a serial transmit-overhead port into a framer. The framer supplies an overhead clock and a strobe that marks the start of each frame. A host asks for one overhead bit to be overwritten by giving a bit index and a bit value, then pulsing a request. The controller waits for the next frame-start strobe and counts overhead-clock rising edges from it. When the count reaches the index, it raises an insert-enable and drives the requested value for exactly one overhead-clock period. The framer can then capture both on the falling edge that follows.

A typical use is raising a far-end receive failure (yellow) indication. The host targets overhead bit 32, which carries the far-end alarm flag of the maintenance byte in an outbound E3 frame. The value to write is supplied by the host, because the alarm polarity depends on the system, so no polarity is fixed in the block. The block reports busy while a request is outstanding and gives a one-cycle done pulse once the bit has been inserted.

All logic is clocked on the rising edge of the overhead clock. The outputs come from registers, so they are settled well before the falling edge that the framer samples.

Top module: `ohi_insert_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ins_en, ins_data, busy and done are all 0.
- R2: A request is taken on a rising edge that samples req high while busy is low. That edge captures req_index and req_value, and busy is 1 from that edge on. A req sampled while busy is 1 is ignored: the insertion that follows uses the first request's index and value.
- R3: After it accepts a request, the controller waits for the next rising edge that samples frame_strobe high. That edge is edge zero. A strobe sampled on the same edge that accepts the request does not count as edge zero, and ins_en stays 0 while the controller waits.
- R4: With target index N, ins_en is 1 only in the cycle that starts with the N-th rising edge after edge zero, for exactly one cycle. N = 0 inserts starting at edge zero itself.
- R5: While ins_en is 1, ins_data equals the requested value (0 or 1 are both honoured). While ins_en is 0, ins_data is 0.
- R6: On the rising edge that lowers ins_en, busy falls and done rises. Done stays high for exactly one cycle.
- R7: If frame_strobe is sampled high again before the target edge is reached, the request is cancelled. Busy falls on that edge, and neither ins_en nor done is raised for it.
- R8: The index is IDX_W (10) bits wide. Every index up to 2^IDX_W - 1 (1023) is counted exactly, including the alarm position 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Overhead clock from the framer; logic uses its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | Frame-start indication, sampled on a rising edge |
| req | input | 1 | Host request pulse to insert one bit |
| req_index | input | IDX_W | Overhead bit index counted from edge zero |
| req_value | input | 1 | Bit value to insert |
| ins_en | output | 1 | Insert enable toward the framer, high for one clock |
| ins_data | output | 1 | Overhead data toward the framer, zero when not inserting |
| busy | output | 1 | A request is pending, counting or inserting |
| done | output | 1 | One-cycle pulse after the insertion period ends |

## Verification
Directed requests cover several cases. One targets the alarm position 32. Others target index 0 and the largest index 1023, which tell apart an edge count off by one at either end and a counter that wraps or saturates early. One request arrives on the same edge as a strobe, which shows whether that strobe is wrongly taken as edge zero. A second request sent while busy shows whether a busy request overwrites the captured index or value. A strobe arriving before the target edge separates a correct cancel from a late insertion. Random requests with random index, value and wait before the strobe then check the exact cycle of ins_en, ins_data, done and busy against the position computed in the bench from the requirements.

// File: rtl/ohi_pkg.sv
package ohi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_COUNT,
    ST_INS
  } ohi_state_e;

  // True when the edge about to be counted is the target one.
  // cnt holds the edges counted since edge zero.
  function automatic logic idx_reached(input int unsigned cnt, input int unsigned tgt);
    return (cnt + 1) == tgt;
  endfunction

  // Saturating increment for the edge counter.
  function automatic int unsigned sat_step(input int unsigned cnt, input int unsigned top);
    return (cnt >= top) ? top : cnt + 1;
  endfunction

endpackage

// File: rtl/ohi_ctrl.sv
module ohi_ctrl #(
  parameter int IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_strobe,
  input  logic                  req,
  input  logic [IDX_W-1:0]      req_index,
  input  logic                  req_value,
  input  logic [IDX_W-1:0]      cnt,
  output ohi_pkg::ohi_state_e   state,
  output logic [IDX_W-1:0]      tgt_q,
  output logic                  val_q,
  output logic                  accept,
  output logic                  cnt_clr,
  output logic                  cnt_inc,
  output logic                  fire,
  output logic                  finish,
  output logic                  cancel
);
  import ohi_pkg::*;

  always_comb begin
    accept  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    fire    = 1'b0;
    finish  = 1'b0;
    cancel  = 1'b0;
    case (state)
      ST_IDLE:  accept = req;
      ST_PEND: begin
        if (frame_strobe) begin
          if (tgt_q == '0) fire = 1'b1;
          else             cnt_clr = 1'b1;
        end
      end
      ST_COUNT: begin
        if (frame_strobe)                              cancel  = 1'b1;
        else if (idx_reached(32'(cnt), 32'(tgt_q)))    fire    = 1'b1;
        else                                           cnt_inc = 1'b1;
      end
      ST_INS:   finish = 1'b1;
      default:  finish = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tgt_q <= '0;
      val_q <= 1'b0;
    end else begin
      if (accept) begin
        state <= ST_PEND;
        tgt_q <= req_index;
        val_q <= req_value;
      end else if (cnt_clr) begin
        state <= ST_COUNT;
      end else if (fire) begin
        state <= ST_INS;
      end else if (finish || cancel) begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/ohi_edge_cnt.sv
module ohi_edge_cnt #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] cnt
);
  import ohi_pkg::*;

  localparam int unsigned CNT_TOP = (1 << IDX_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= IDX_W'(sat_step(32'(cnt), CNT_TOP));
  end

endmodule

// File: rtl/ohi_out_drv.sv
module ohi_out_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic finish,
  input  logic val,
  output logic ins_en,
  output logic ins_data,
  output logic done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_en   <= 1'b0;
      ins_data <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (fire) begin
        ins_en   <= 1'b1;
        ins_data <= val;
      end else if (finish) begin
        ins_en   <= 1'b0;
        ins_data <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ohi_insert_ctrl.sv
module ohi_insert_ctrl #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_strobe,
  input  logic             req,
  input  logic [IDX_W-1:0] req_index,
  input  logic             req_value,
  output logic             ins_en,
  output logic             ins_data,
  output logic             busy,
  output logic             done
);
  import ohi_pkg::*;

  ohi_state_e       state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] tgt_q;
  logic             val_q;
  logic             accept, cnt_clr, cnt_inc, fire, finish, cancel;
  logic             pending;

  ohi_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .req          (req),
    .req_index    (req_index),
    .req_value    (req_value),
    .cnt          (cnt),
    .state        (state),
    .tgt_q        (tgt_q),
    .val_q        (val_q),
    .accept       (accept),
    .cnt_clr      (cnt_clr),
    .cnt_inc      (cnt_inc),
    .fire         (fire),
    .finish       (finish),
    .cancel       (cancel)
  );

  ohi_edge_cnt #(.IDX_W(IDX_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  ohi_out_drv drv_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .finish   (finish),
    .val      (val_q),
    .ins_en   (ins_en),
    .ins_data (ins_data),
    .done     (done)
  );

  assign busy    = (state != ST_IDLE);
  assign pending = (state == ST_PEND);

endmodule

// File: rtl/ohi_checker.sv
module ohi_checker #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_strobe,
  input logic             req,
  input logic             busy,
  input logic             ins_en,
  input logic             ins_data,
  input logic             done,
  input logic             accept,
  input logic             cancel,
  input logic             pending,
  input logic             val_q,
  input logic [IDX_W-1:0] tgt_q
);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r2_busy_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> ($stable(val_q) && $stable(tgt_q)));

  a_r3_wait_for_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !frame_strobe) |=> !ins_en);

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> !ins_en);

  a_r5_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_en |-> !ins_data);

  a_r5_value_held: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (ins_data == val_q));

  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ins_en) |-> (done && !busy));

  a_r6_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ins_en));

  a_r7_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!busy && !ins_en && !done));

endmodule

bind ohi_insert_ctrl ohi_checker #(.IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_strobe (frame_strobe),
  .req          (req),
  .busy         (busy),
  .ins_en       (ins_en),
  .ins_data     (ins_data),
  .done         (done),
  .accept       (accept),
  .cancel       (cancel),
  .pending      (pending),
  .val_q        (val_q),
  .tgt_q        (tgt_q)
);

// File: tb/ohi_insert_ctrl_tb_top.sv
module ohi_insert_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 10;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_strobe = 1'b0;
  logic             req = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic             req_value = 1'b0;
  logic             ins_en, ins_data, busy, done;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ohi_insert_ctrl #(.IDX_W(IDX_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .req          (req),
    .req_index    (req_index),
    .req_value    (req_value),
    .ins_en       (ins_en),
    .ins_data     (ins_data),
    .busy         (busy),
    .done         (done)
  );

  // Expected outputs at the sample point k cycles after edge zero.
  function automatic logic exp_en(int k, int n);
    return k == n;
  endfunction
  function automatic logic exp_data(int k, int n, logic v);
    return (k == n) ? v : 1'b0;
  endfunction
  function automatic logic exp_done(int k, int n);
    return k == n + 1;
  endfunction
  function automatic logic exp_busy(int k, int n);
    return k <= n;
  endfunction

  task automatic check(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Request, optional wait, strobe, then watch the window around the target.
  task automatic run_case(int n, logic v, int gap, bit same_edge, bit dup);
    @(negedge clk);
    req = 1'b1; req_index = IDX_W'(n); req_value = v; frame_strobe = same_edge;
    @(negedge clk);
    req = 1'b0; frame_strobe = 1'b0;
    check("R2 busy after accept", int'(busy), 1);
    for (int g = 0; g < gap; g++) begin
      check("R3 no insert before edge zero", int'(ins_en), 0);
      if (dup && g == 0) begin
        req = 1'b1; req_index = IDX_W'((n + 3) % 7); req_value = ~v;
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
    end
    req = 1'b0;
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
    for (int k = 0; k <= n + 2; k++) begin
      check("R4 ins_en timing", int'(ins_en), int'(exp_en(k, n)));
      check("R5 ins_data value", int'(ins_data), int'(exp_data(k, n, v)));
      check("R6 done pulse", int'(done), int'(exp_done(k, n)));
      check("R6 busy span", int'(busy), int'(exp_busy(k, n)));
      @(negedge clk);
    end
  endtask

  task automatic cancel_case();
    @(negedge clk);
    req = 1'b1; req_index = IDX_W'(50); req_value = 1'b1;
    @(negedge clk);
    req = 1'b0;
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
    for (int k = 0; k < 20; k++) begin
      check("R7 no insert before cancel", int'(ins_en), 0);
      check("R7 busy before cancel", int'(busy), 1);
      if (k == 19) frame_strobe = 1'b1;
      @(negedge clk);
    end
    frame_strobe = 1'b0;
    check("R7 busy dropped on cancel", int'(busy), 0);
    for (int k = 0; k < 40; k++) begin
      check("R7 no insert after cancel", int'(ins_en), 0);
      check("R7 no done after cancel", int'(done), 0);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_0a1c));
    repeat (3) @(negedge clk);
    check("R1 ins_en in reset", int'(ins_en), 0);
    check("R1 ins_data in reset", int'(ins_data), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ins_en after reset", int'(ins_en), 0);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);

    run_case(32, 1'b1, 4, 1'b0, 1'b0);   // R8 alarm bit position, value 1
    run_case(32, 1'b0, 2, 1'b0, 1'b0);   // R5 value 0
    run_case(0,  1'b1, 1, 1'b0, 1'b0);   // R4 index zero
    run_case(5,  1'b1, 3, 1'b1, 1'b0);   // R3 strobe on accept edge
    run_case(9,  1'b1, 3, 1'b0, 1'b1);   // R2 request while busy ignored
    cancel_case();                       // R7
    run_case(1023, 1'b1, 1, 1'b0, 1'b0); // R8 largest index

    for (int i = 0; i < 25; i++) begin
      run_case(int'($urandom_range(0, 60)), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)), 1'b0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule